// File: doc/BRIEF.md
# Double-Buffered Crosspoint Selection Switch

This block is a single-bit crosspoint with 17 inputs and 17 outputs. Each output is steered by a 17:1 multiplexer, so one input can feed any number of outputs at once. Every output has two selection registers. The queued register is loaded from a parallel host bus. The active register drives that output's multiplexer.

A host loads new selections into the queued registers one write at a time. It then raises a configure line, and every queued selection takes effect on the same clock edge. If the configure line is held high, the active registers follow the queued ones and each write takes effect at once.

The bus is modelled as synchronous logic in one system clock domain. The bidirectional data bus is split into a data-in port, a data-out port and an output-enable. A transparent address latch serves hosts that multiplex address and data on the same wires. Address space beyond the real outputs holds extra selection registers that a host can read and write, but that steer nothing.

Top module: `xpt_cfg_switch`

## Requirements
- R1: Synchronous active-low reset sets every queued and active selection to input 0. After reset each output copies input 0, and readback returns 0.
- R2: A write stores `host_din` into the queued register named by the address on the cycle where `host_wr_n` goes from 0 to 1 while `host_cs_n` is 0. A write strobe seen while `host_cs_n` is 1 stores nothing.
- R3: A queued write does not change any output until a commit.
- R4: Each clock edge on which `host_cfg` is 1 and `host_cs_n` is 0 copies every queued selection into its active register. If `host_cfg` is raised while `host_cs_n` is 1, nothing changes.
- R5: While `host_cfg` stays 1 with `host_cs_n` at 0, a write updates the active selection on the same edge that updates the queued one.
- R6: Output o carries `sw_in[s]`, where s is the binary input number in its active selection. Several outputs may select the same input.
- R7: Addresses 0 to 16 select the real outputs 0 to 16. Addresses 17 to 32 are readable and writable selection registers that drive no output. Writes to addresses 33 to 63 are dropped, and reads there return 0.
- R8: While `host_rd_n` and `host_cs_n` are both 0, the next clock edge sets `host_doe` to 1 and puts the queued selection at the current address on `host_dout`. Otherwise `host_doe` is 0 after the next edge.
- R9: While `host_ale` is 0 the address latch follows `host_addr`. While `host_ale` is 1 the latch holds the last captured address, and all accesses use that held address.
- R10: An active selection above 16 drives its output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_wr_n | input | 1 | Write strobe, active low; the store happens on its rising edge |
| host_rd_n | input | 1 | Read strobe, active low |
| host_ale | input | 1 | Address latch enable; the latch is transparent while low |
| host_cfg | input | 1 | Configure / commit, active high |
| host_addr | input | 6 | Register address |
| host_din | input | 5 | Write data: input number in binary |
| host_dout | output | 5 | Read data |
| host_doe | output | 1 | Read data output enable |
| sw_in | input | 17 | Crosspoint inputs |
| sw_out | output | 17 | Crosspoint outputs |

## Verification
The bench builds the block with its default parameters: 17 inputs, 17 outputs, 33 selection registers, a 6-bit address and a 5-bit data field. These values reach the last real output (address 16), the first and last internal registers (17 and 32), and the unmapped addresses above 32. They also allow input numbers 17 to 31, which exercise the forced-zero output. With 17 inputs, one-hot and mixed input patterns separate every selection, so a wrong route or a stale active register shows up directly on `sw_out`.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    // Default geometry of the crosspoint and its host bus
    localparam int XPT_NIN  = 17;
    localparam int XPT_NOUT = 17;
    localparam int XPT_NREG = 33;
    localparam int XPT_AW   = 6;
    localparam int XPT_DW   = 5;
endpackage

// File: rtl/xpt_bus_ctl.sv
// Host bus front end. It holds the transparent address latch, detects the
// rising edge of the write strobe, forms the commit strobe and registers the
// read data.
// Assumes all bus inputs are synchronous to clk.
module xpt_bus_ctl #(
    parameter int AW = 6,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          ale,
    input  logic          cfg,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] eff_addr,
    output logic          wr_stb,
    output logic          cfg_stb,
    output logic [DW-1:0] dout,
    output logic          doe
);
    logic [AW-1:0] addr_q;
    logic          wr_n_q;

    // Latch the address while ale is low
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (!ale) addr_q <= addr;
    end

    // The latch is transparent while ale is low
    assign eff_addr = ale ? addr_q : addr;

    // Remember the previous write strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= wr_n;
    end

    // Rising edge of wr_n, qualified by chip select
    assign wr_stb  = !wr_n_q && wr_n && !cs_n;
    // Commit is level sensitive, so holding cfg high makes it transparent
    assign cfg_stb = cfg && !cs_n;

    // Register read data and its enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            doe  <= 1'b0;
        end else begin
            doe  <= !rd_n && !cs_n;
            dout <= (!rd_n && !cs_n) ? rd_data : '0;
        end
    end

    // R8
    doe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !cs_n) |=> doe);
    // R8
    doe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || cs_n) |=> !doe);
endmodule

// File: rtl/xpt_sel_bank.sv
// Selection register file. It holds one queued register per address and one
// active register per real output. A commit copies the next queued state into
// the active registers, so a write and a commit on the same edge both land.
// Assumes NOUT <= NREG and NREG <= 2**AW.
module xpt_sel_bank #(
    parameter int NREG = 33,
    parameter int NOUT = 17,
    parameter int AW   = 6,
    parameter int DW   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic                    cfg_stb,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           din,
    output logic [DW-1:0]           rd_data,
    output logic [NOUT-1:0][DW-1:0] act_sel
);
    logic [DW-1:0] q_reg  [NREG];
    logic [DW-1:0] q_next [NREG];

    // Next queued state with the current write applied
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            q_next[k] = q_reg[k];
            if (wr_stb && addr == AW'(k)) q_next[k] = din;
        end
    end

    // Queued register update
    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (!rst_n) q_reg[k] <= '0;
            else        q_reg[k] <= q_next[k];
        end
    end

    // Readback of the queued value; unmapped addresses read 0
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (addr == AW'(k)) rd_data = q_reg[k];
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_act
        // Active register for one output, loaded on commit
        always_ff @(posedge clk) begin
            if (!rst_n)       act_sel[o] <= '0;
            else if (cfg_stb) act_sel[o] <= q_next[o];
        end

        // R3
        act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_stb |=> $stable(act_sel[o]));
        // R4
        act_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_stb && !wr_stb) |=> act_sel[o] == $past(q_reg[o]));
        // R2
        q_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && addr == AW'(o)) |=> q_reg[o] == $past(din));
    end
endmodule

// File: rtl/xpt_out_mux.sv
// One NIN:1 multiplexer per output, steered by that output's active
// selection. A selection outside 0..NIN-1 drives 0.
module xpt_out_mux #(
    parameter int NIN  = 17,
    parameter int NOUT = 17,
    parameter int DW   = 5
) (
    input  logic [NOUT-1:0][DW-1:0] act_sel,
    input  logic [NIN-1:0]          sw_in,
    output logic [NOUT-1:0]         sw_out
);
    for (genvar o = 0; o < NOUT; o++) begin : g_mux
        // Select one input bit for output o
        always_comb begin
            sw_out[o] = 1'b0;
            for (int i = 0; i < NIN; i++)
                if (act_sel[o] == DW'(i)) sw_out[o] = sw_in[i];
        end
    end
endmodule

// File: rtl/xpt_cfg_switch.sv
// Top level of the double-buffered crosspoint. It joins the bus front end,
// the selection register file and the output multiplexers.
// Assumes a synchronous host bus and an active-low synchronous reset.
module xpt_cfg_switch
    import xpt_pkg::*;
#(
    parameter int NIN  = XPT_NIN,
    parameter int NOUT = XPT_NOUT,
    parameter int NREG = XPT_NREG,
    parameter int AW   = XPT_AW,
    parameter int DW   = XPT_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_cs_n,
    input  logic            host_wr_n,
    input  logic            host_rd_n,
    input  logic            host_ale,
    input  logic            host_cfg,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_din,
    output logic [DW-1:0]   host_dout,
    output logic            host_doe,
    input  logic [NIN-1:0]  sw_in,
    output logic [NOUT-1:0] sw_out
);
    logic [AW-1:0]           eff_addr;
    logic                    wr_stb;
    logic                    cfg_stb;
    logic [DW-1:0]           rd_data;
    logic [NOUT-1:0][DW-1:0] act_sel;

    xpt_bus_ctl #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(host_cs_n), .wr_n(host_wr_n),
        .rd_n(host_rd_n), .ale(host_ale), .cfg(host_cfg), .addr(host_addr),
        .rd_data(rd_data), .eff_addr(eff_addr), .wr_stb(wr_stb),
        .cfg_stb(cfg_stb), .dout(host_dout), .doe(host_doe)
    );

    xpt_sel_bank #(.NREG(NREG), .NOUT(NOUT), .AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cfg_stb(cfg_stb),
        .addr(eff_addr), .din(host_din), .rd_data(rd_data), .act_sel(act_sel)
    );

    xpt_out_mux #(.NIN(NIN), .NOUT(NOUT), .DW(DW)) u_mux (
        .act_sel(act_sel), .sw_in(sw_in), .sw_out(sw_out)
    );

    for (genvar o = 1; o < NOUT; o++) begin : g_fan
        // R6
        fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_sel[o] == act_sel[0]) |-> (sw_out[o] == sw_out[0]));
    end
endmodule

// File: tb/xpt_cfg_switch_test.sv
module xpt_cfg_switch_test;
    localparam int NIN = 17, NOUT = 17, NREG = 33;

    typedef struct packed { logic [5:0] a; logic [4:0] s; } vec_t;
    localparam vec_t VECS [8] = '{
        '{a: 6'd4,  s: 5'd6},  '{a: 6'd0,  s: 5'd16}, '{a: 6'd16, s: 5'd3},
        '{a: 6'd7,  s: 5'd6},  '{a: 6'd10, s: 5'd6},  '{a: 6'd3,  s: 5'd0},
        '{a: 6'd12, s: 5'd21}, '{a: 6'd4,  s: 5'd9}
    };
    localparam logic [16:0] PATS [3] = '{17'h00040, 17'h1A5C3, 17'h10001};

    logic clk = 0, rst_n = 0;
    logic cs_n = 1, wr_n = 1, rd_n = 1, ale = 0, cfg = 0;
    logic [5:0] addr = 0;
    logic [4:0] din = 0, dout;
    logic doe;
    logic [16:0] sw_in = 0, sw_out;
    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [4:0] mq [NREG];
    logic [4:0] ma [NOUT];

    always #4 clk = ~clk;

    xpt_cfg_switch uut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_wr_n(wr_n),
        .host_rd_n(rd_n), .host_ale(ale), .host_cfg(cfg), .host_addr(addr),
        .host_din(din), .host_dout(dout), .host_doe(doe),
        .sw_in(sw_in), .sw_out(sw_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] model_out(input logic [16:0] pin);
        logic [16:0] r = '0;
        for (int o = 0; o < NOUT; o++) r[o] = (ma[o] < 5'd17) ? pin[ma[o]] : 1'b0;
        return r;
    endfunction

    task automatic wr(input int a, input int d, input bit sel, input bit cfg_hold);
        @(negedge clk); addr = 6'(a); din = 5'(d); cs_n = !sel; wr_n = 0; cfg = cfg_hold;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 1; cfg = 0;
        if (sel && a < NREG) begin
            mq[a] = 5'(d);
            if (cfg_hold) for (int o = 0; o < NOUT; o++) ma[o] = mq[o];
        end
    endtask

    task automatic commit(input bit sel);
        @(negedge clk); cs_n = !sel; cfg = 1;
        @(negedge clk); cs_n = 1; cfg = 0;
        if (sel) for (int o = 0; o < NOUT; o++) ma[o] = mq[o];
    endtask

    task automatic rd(input int a, output logic [4:0] v, output logic en);
        @(negedge clk); addr = 6'(a); cs_n = 0; rd_n = 0;
        @(negedge clk); v = dout; en = doe; rd_n = 1; cs_n = 1;
    endtask

    task automatic out_chk(input string req, input logic [16:0] pin);
        @(negedge clk); sw_in = pin;
        #1 chk(sw_out === model_out(pin), req, int'(sw_out), int'(model_out(pin)));
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] v;
        logic en;
        for (int k = 0; k < NREG; k++) mq[k] = 0;
        for (int o = 0; o < NOUT; o++) ma[o] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, outputs follow input 0
        sw_in = 17'h00001; #1
        chk(sw_out === 17'h1FFFF, "R1 all follow in0", int'(sw_out), 'h1FFFF);
        @(negedge clk); sw_in = 17'h1FFFE; #1
        chk(sw_out === 17'h0, "R1 in0 low", int'(sw_out), 0);
        rd(16, v, en);
        chk(v === 5'd0 && en === 1'b1, "R1/R8 readback after reset", int'(v), 0);
        @(negedge clk); #1 chk(doe === 1'b0, "R8 doe idle", int'(doe), 0);

        // R6/R10: table walk of write+commit with several input patterns
        foreach (VECS[i]) begin
            wr(int'(VECS[i].a), int'(VECS[i].s), 1'b1, 1'b0);
            commit(1'b1);
            for (int p = 0; p < 3; p++) out_chk("R6/R10 table route", PATS[p]);
        end
        // R10 explicit: output 12 selects 21, stays 0 under all ones
        @(negedge clk); sw_in = 17'h1FFFF; #1
        chk(sw_out[12] === 1'b0, "R10 out-of-range select", int'(sw_out[12]), 0);

        // R3: queued write without commit leaves outputs alone
        wr(2, 5, 1'b1, 1'b0);
        out_chk("R3 no change before commit", 17'h00020);
        rd(2, v, en);
        chk(v === 5'd5, "R8 readback of queued value", int'(v), 5);
        // R2: write with chip select high is dropped
        wr(2, 9, 1'b0, 1'b0);
        rd(2, v, en);
        chk(v === 5'd5, "R2 write ignored with cs high", int'(v), 5);
        // R4: commit with cs high ignored, then a proper commit moves two outputs
        wr(1, 8, 1'b1, 1'b0);
        commit(1'b0);
        out_chk("R4 commit ignored with cs high", 17'h00120);
        commit(1'b1);
        out_chk("R4 commit moves queued outputs together", 17'h00120);
        chk(sw_out[1] === 1'b1 && sw_out[2] === 1'b1, "R4 both outputs switched",
            int'(sw_out[2:1]), 3);

        // R5: configure held high makes a write take effect at once
        wr(5, 13, 1'b1, 1'b1);
        out_chk("R5 transparent write", 17'h02000);
        chk(sw_out[5] === 1'b1, "R5 out5 follows in13", int'(sw_out[5]), 1);

        // R7: internal and unmapped addresses
        wr(20, 11, 1'b1, 1'b0);
        wr(32, 7, 1'b1, 1'b0);
        commit(1'b1);
        out_chk("R7 internal register drives nothing", 17'h00880);
        rd(20, v, en);
        chk(v === 5'd11, "R7 internal readback 20", int'(v), 11);
        rd(32, v, en);
        chk(v === 5'd7, "R7 internal readback 32", int'(v), 7);
        wr(40, 7, 1'b1, 1'b0);
        rd(40, v, en);
        chk(v === 5'd0 && en === 1'b1, "R7 unmapped reads 0", int'(v), 0);

        // R9: address held by latch while ale is high
        @(negedge clk); ale = 0; addr = 6'd6;
        @(negedge clk); ale = 1; addr = 6'd9; din = 5'd14; cs_n = 0; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 1;
        mq[6] = 5'd14;
        @(negedge clk); ale = 0;
        rd(6, v, en);
        chk(v === 5'd14, "R9 write went to latched address", int'(v), 14);
        rd(9, v, en);
        chk(v === 5'd0, "R9 bus address ignored while latched", int'(v), 0);

        // R1: reset again clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; sw_in = 17'h00001;
        for (int o = 0; o < NOUT; o++) ma[o] = 0;
        for (int k = 0; k < NREG; k++) mq[k] = 0;
        #1 chk(sw_out === 17'h1FFFF, "R1 second reset", int'(sw_out), 'h1FFFF);
        rd(6, v, en);
        chk(v === 5'd0, "R1 queued cleared", int'(v), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule